// File: doc/BRIEF.md
# Address-Transition Power-Gated Memory Controller

This block sits in front of a small synchronous memory array and keeps the array powered down unless an access actually needs it. Each clock it compares the incoming address with the address seen on the previous clock. When the address moves, when the select input rises, or when a write is requested, it wakes the array for a fixed number of cycles. During that window it fetches the addressed word and then captures it in an output holding register. After that the array goes back to sleep. The host sees stable read data on `rdata_o` between accesses without keeping the array powered.

A write uses the same window. The word is written into the array, and because a write always targets the address currently presented, the holding register picks up the new word as well. A digital `backup_i` flag, raised by external supply monitoring, forces the array into retention. While it is high, every access is ignored and the held output is frozen. When the flag is released with the select still high, a refresh read of the current address is issued.

Top module: `zp_mem_ctrl`

## Requirements
- R1: While reset is asserted and after release, `rdata_o` is 0 and `array_en_o` is 0 until the first access.
- R2: `array_en_o` is 0 whenever no wake window is running. With the select high and address, write and backup inputs unchanged, it stays 0 and `rdata_o` stays constant.
- R3: When `addr_i` changes while `cs_i` is 1 and `backup_i` is 0, `array_en_o` is 1 for exactly ACTIVE_CYC cycles, starting the cycle after the change. `rdata_o` shows the array word at that address from the clock edge that ends the window.
- R4: A rising `cs_i` with an unchanged address starts a wake window and a read of the presented address, exactly as in R3.
- R5: An address change during a wake window restarts the window from its first cycle. `rdata_o` keeps its old value until the restarted window ends, then shows the word at the final address.
- R6: A one-cycle pulse on `wr_i` with `cs_i` 1 writes `wdata_i` at `addr_i` and wakes the array for the same ACTIVE_CYC cycles. At the end of the window `rdata_o` shows the written word, and later reads of that address return it.
- R7: While `cs_i` is 0, address changes start no window, `array_en_o` stays 0 and `rdata_o` is unchanged.
- R8: While `backup_i` is 1, `array_en_o` is 0 in the same cycle, reads and writes are ignored (array contents unchanged) and `rdata_o` holds its value. Releasing `backup_i` with `cs_i` 1 starts a refresh read of the current address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Block select, active high |
| addr_i | input | ADDR_W | Word address |
| wr_i | input | 1 | Write request, one-cycle pulse |
| wdata_i | input | DATA_W | Write data |
| backup_i | input | 1 | Retention request from supply monitoring |
| rdata_o | output | DATA_W | Held read data |
| array_en_o | output | 1 | Array power/enable, active high |

## Verification
The hardest case to reach is a restart in the middle of a window. The second address must arrive while the array is awake but before the holding register loads, and `rdata_o` must never show the word of the abandoned address. The stimulus drives one address, samples `array_en_o` high one cycle later, and then moves the address again in that same cycle before the window closes. A second hard case is a write issued during backup, whose absence can only be seen after release. The release itself triggers a refresh read of that address, which must return the old word.

// File: rtl/zp_pkg.sv
package zp_pkg;

    typedef enum logic {
        ST_SLEEP = 1'b0,
        ST_AWAKE = 1'b1
    } zp_state_e;

endpackage

// File: rtl/zp_xition_det.sv
module zp_xition_det #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              backup_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              trig_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              sel;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d.addr = addr_i;
        det_d.sel  = cs_i & ~backup_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    // Wake on address movement, select rise (including backup release) or write.
    assign trig_o = cs_i & ~backup_i & ((addr_i != det_q.addr) | ~det_q.sel | wr_i);

    // R4: a select rise outside backup always wakes the array
    a_r4_select_rise_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_i) && !backup_i) |-> trig_o);

endmodule

// File: rtl/zp_array.sv
module zp_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              en_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_q;

    // Behavioural array: only an enabled cycle touches storage or the read port.
    always_ff @(posedge clk) begin
        if (en_i) begin
            if (we_i) begin
                mem_q[addr_i] <= wdata_i;
                rd_q          <= wdata_i;
            end else begin
                rd_q          <= mem_q[addr_i];
            end
        end
    end

    assign rdata_o = rd_q;

endmodule

// File: rtl/zp_sequencer.sv
module zp_sequencer
    import zp_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 8,
    parameter int ACTIVE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              backup_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] arr_rdata_i,
    output logic              arr_en_o,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [DATA_W-1:0] arr_wdata_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int              CNT_W    = (ACTIVE_CYC > 2) ? $clog2(ACTIVE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACTIVE_CYC - 1);

    typedef struct packed {
        zp_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] fa;
        logic              wp;
        logic [DATA_W-1:0] wd;
        logic [DATA_W-1:0] hold;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        seq_d.wp = 1'b0;
        if (backup_i) begin
            seq_d.st = ST_SLEEP;
        end else if (trig_i) begin
            seq_d.st  = ST_AWAKE;
            seq_d.cnt = CNT_LAST;
            seq_d.fa  = addr_i;
            seq_d.wp  = wr_i;
            seq_d.wd  = wdata_i;
        end else if (seq_q.st == ST_AWAKE) begin
            if (seq_q.cnt == '0) begin
                seq_d.hold = arr_rdata_i;
                seq_d.st   = ST_SLEEP;
            end else begin
                seq_d.cnt = seq_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign arr_en_o    = (seq_q.st == ST_AWAKE) & ~backup_i;
    assign arr_we_o    = arr_en_o & seq_q.wp;
    assign arr_addr_o  = seq_q.fa;
    assign arr_wdata_o = seq_q.wd;
    assign rdata_o     = seq_q.hold;

    // R3: every wake window opens on its first count
    a_r3_window_opens_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_en_o) |-> (seq_q.cnt == CNT_LAST));

    // R2: the last cycle of a window with no new trigger is followed by sleep
    a_r2_sleep_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_en_o && seq_q.cnt == '0 && !trig_i) |=> !arr_en_o);

    // R8: backup freezes the held output
    a_r8_backup_holds_output: assert property (@(posedge clk) disable iff (!rst_n)
        backup_i |=> $stable(rdata_o));

endmodule

// File: rtl/zp_mem_ctrl.sv
module zp_mem_ctrl #(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 8,
    parameter int ACTIVE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              backup_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              array_en_o
);

    logic              trig;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [DATA_W-1:0] arr_wdata;
    logic [DATA_W-1:0] arr_rdata;

    zp_xition_det #(
        .ADDR_W (ADDR_W)
    ) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_i     (cs_i),
        .backup_i (backup_i),
        .wr_i     (wr_i),
        .addr_i   (addr_i),
        .trig_o   (trig)
    );

    zp_sequencer #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .ACTIVE_CYC (ACTIVE_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (trig),
        .backup_i    (backup_i),
        .wr_i        (wr_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .arr_rdata_i (arr_rdata),
        .arr_en_o    (array_en_o),
        .arr_we_o    (arr_we),
        .arr_addr_o  (arr_addr),
        .arr_wdata_o (arr_wdata),
        .rdata_o     (rdata_o)
    );

    zp_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_arr (
        .clk     (clk),
        .en_i    (array_en_o),
        .we_i    (arr_we),
        .addr_i  (arr_addr),
        .wdata_i (arr_wdata),
        .rdata_o (arr_rdata)
    );

    // R7: a deselected, sleeping block stays asleep
    a_r7_deselect_stays_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_i && !array_en_o) |=> !array_en_o);

    // R8: the array is never powered in the cycle after backup was requested
    a_r8_backup_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (backup_i && $past(backup_i)) |-> !array_en_o);

endmodule

// File: tb/test_zp_mem_ctrl.sv
module test_zp_mem_ctrl;

    localparam int AW = 6;
    localparam int DW = 8;
    localparam int N  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          wr_i = 1'b0;
    logic [DW-1:0] wdata_i = '0;
    logic          backup_i = 1'b0;
    logic [DW-1:0] rdata_o;
    logic          array_en_o;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [1 << AW];

    always #2.5 clk = ~clk;

    zp_mem_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ACTIVE_CYC(N)) i_zp_mem_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_i       (cs_i),
        .addr_i     (addr_i),
        .wr_i       (wr_i),
        .wdata_i    (wdata_i),
        .backup_i   (backup_i),
        .rdata_o    (rdata_o),
        .array_en_o (array_en_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sample one window: enable high for N negedges, data valid on the next one.
    task automatic run_window(input string req, input logic [DW-1:0] exp_d,
                              input logic [DW-1:0] old_d);
        for (int k = 1; k <= N + 1; k++) begin
            @(negedge clk);
            chk(array_en_o == (k <= N), req, int'(array_en_o), int'(k <= N));
            if (k <= N) chk(rdata_o == old_d, req, rdata_o, old_d);
            else        chk(rdata_o == exp_d, req, rdata_o, exp_d);
            wr_i = 1'b0;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(rdata_o == '0, "R1", rdata_o, 0);
        chk(array_en_o == 1'b0, "R1", int'(array_en_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(array_en_o == 1'b0, "R1", int'(array_en_o), 0);
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] old_d = rdata_o;
        cs_i = 1'b1; addr_i = a; wdata_i = d; wr_i = 1'b1;
        model[a] = d;
        run_window("R6", d, old_d);
    endtask

    task automatic t_read(input logic [AW-1:0] a);
        logic [DW-1:0] old_d = rdata_o;
        cs_i = 1'b1; addr_i = a;
        run_window("R3", model[a], old_d);
    endtask

    task automatic t_idle();
        logic [DW-1:0] old_d = rdata_o;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(array_en_o == 1'b0, "R2", int'(array_en_o), 0);
            chk(rdata_o == old_d, "R2", rdata_o, old_d);
        end
    endtask

    task automatic t_restart(input logic [AW-1:0] a, input logic [AW-1:0] b);
        logic [DW-1:0] old_d = rdata_o;
        cs_i = 1'b1; addr_i = a;
        @(negedge clk);
        chk(array_en_o == 1'b1, "R5", int'(array_en_o), 1);
        addr_i = b;
        run_window("R5", model[b], old_d);
    endtask

    task automatic t_deselect_then_rise(input logic [AW-1:0] a);
        logic [DW-1:0] old_d = rdata_o;
        cs_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            addr_i = a + AW'(k);
            @(negedge clk);
            chk(array_en_o == 1'b0, "R7", int'(array_en_o), 0);
            chk(rdata_o == old_d, "R7", rdata_o, old_d);
        end
        addr_i = a;
        @(negedge clk);
        chk(array_en_o == 1'b0, "R7", int'(array_en_o), 0);
        cs_i = 1'b1;
        run_window("R4", model[a], old_d);
    endtask

    task automatic t_backup(input logic [AW-1:0] a);
        logic [DW-1:0] old_d = rdata_o;
        backup_i = 1'b1;
        #0.1;
        chk(array_en_o == 1'b0, "R8", int'(array_en_o), 0);
        addr_i = a; wdata_i = ~model[a]; wr_i = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(array_en_o == 1'b0, "R8", int'(array_en_o), 0);
            chk(rdata_o == old_d, "R8", rdata_o, old_d);
            wr_i = 1'b0;
        end
        backup_i = 1'b0;
        run_window("R8", model[a], old_d);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        for (int i = 0; i < 8; i++) t_write(AW'(i), DW'(8'h30 + i * 7));
        t_read(6'd3);
        t_read(6'd5);
        t_read(6'd1);
        t_idle();
        t_restart(6'd2, 6'd6);
        t_deselect_then_rise(6'd4);
        t_backup(6'd7);
        t_write(6'd7, 8'h5A);
        t_read(6'd6);
        t_read(6'd7);
        t_idle();
        finish_run();
    end

endmodule